// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Flags

This block queues 36-bit words from a producer running on one clock to a consumer running on another clock. The two clocks may be unrelated or may be the same net. It holds 64 words. The write side accepts a word on a rising write-clock edge when its strobes qualify it. The read side loads the oldest word into an output register on a qualified read-clock edge.

Each side sees its own active-low status flags, and each flag is timed to that side's clock. The write side gets full and almost-full. The read side gets empty and almost-empty. The almost flags compare against a threshold X. X is one of four presets, and a two-bit select chosen at the moment reset is released picks which one.

Pointers cross between the clock domains in Gray code through two-stage synchronisers. A flag that is released because the other side moved therefore changes on the second edge of the observing clock.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were written, bit-exact over 36 bits. After exactly 64 accepted writes with no reads, `full_no` is low.
- R2: A write is accepted only on a rising `wclk_i` edge with `w_cs_ni`=0, `w_en_i`=1 and `w_dir_i`=1. If any of the three differs, nothing is stored.
- R3: A read happens only on a rising `rclk_i` edge with `r_cs_ni`=0, `r_en_i`=1 and `r_dir_i`=0. The word appears on `r_data_o` right after that edge and holds until the next read.
- R4: `empty_no` is low while no word is stored. After a write into an empty FIFO, it is still low after read-clock edges 0 and 1 following the write edge, and it is high after edge 2. It goes low right after the read that removes the last word.
- R5: `full_no` rises on the second `wclk_i` edge after `rst_ni` is released. After a read from a full FIFO it rises on the second write-clock edge after the read edge.
- R6: A write attempted while `full_no` is low does not move the write pointer and does not store a word. A read attempted while `empty_no` is low does not move the read pointer and leaves `r_data_o` unchanged.
- R7: `aempty_no` is low when the word count seen on the read side is at most X, and high when it is above X.
- R8: `afull_no` is low when the count of free locations seen on the write side is at most X, and high when it is above X.
- R9: The value of `ofs_sel_i` on the rising edge of `rst_ni` picks X: 00 gives 16, 01 gives 12, 10 gives 8, 11 gives 4. Changing `ofs_sel_i` after release has no effect.
- R10: While `rst_ni` is low, whatever the clocks do, `full_no`=0, `afull_no`=1, `empty_no`=0 and `aempty_no`=0. A reset needs at least four edges of each clock with `rst_ni` held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its rising edge latches the offset select |
| ofs_sel_i | input | 2 | Offset preset select |
| w_cs_ni | input | 1 | Write-side chip select, active low |
| w_en_i | input | 1 | Write-side enable |
| w_dir_i | input | 1 | Write-side direction, 1 = write |
| w_data_i | input | 36 | Write data |
| full_no | output | 1 | Full flag, active low, write clock |
| afull_no | output | 1 | Almost-full flag, active low, write clock |
| r_cs_ni | input | 1 | Read-side chip select, active low |
| r_en_i | input | 1 | Read-side enable |
| r_dir_i | input | 1 | Read-side direction, 0 = read |
| r_data_o | output | 36 | Read output register |
| empty_no | output | 1 | Empty flag, active low, read clock |
| aempty_no | output | 1 | Almost-empty flag, active low, read clock |

## Verification
The bench builds the block with its defaults: 36-bit words, depth 64, two synchroniser stages, and offset base 16 with step 4. Both clocks come from one 100 MHz source, so every synchroniser delay lands on a known edge. That lets the bench pin down the second-edge release of the empty and full flags. At depth 64, filling to full, pushing against a full FIFO and draining to empty each take a few dozen cycles. The bench repeats this for each of the four offset presets and checks the almost flags exactly on both sides of each threshold.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    OFS_WIDE   = 2'b00,
    OFS_MID    = 2'b01,
    OFS_NARROW = 2'b10,
    OFS_TIGHT  = 2'b11
  } ofs_sel_e;

  // preset threshold: base minus step per code
  function automatic int unsigned ofs_value(ofs_sel_e sel, int unsigned base, int unsigned step);
    return base - step * 32'(sel);
  endfunction
endpackage

// File: rtl/xclk_ptr_sync.sv
module xclk_ptr_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/xclk_gray2bin.sv
module xclk_gray2bin #(
  parameter int W = 7
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  timeunit 1ns; timeprecision 1ps;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/xclk_fifo_wr.sv
module xclk_fifo_wr #(
  parameter int DEPTH  = 64,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [PW-1:0] rgray_i,
  input  logic [PW-1:0] ofs_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] wgray_o,
  output logic [PW-1:0] rbin_o,
  output logic          push_o,
  output logic          full_no,
  output logic          afull_no
);
  timeunit 1ns; timeprecision 1ps;

  logic          ready;
  logic [PW-1:0] rgray_s, used, free, wptr_nx;

  xclk_ptr_sync #(.W(1), .STAGES(STAGES)) u_rdy (
    .clk_i, .rst_ni, .d_i(1'b1), .q_o(ready)
  );

  xclk_ptr_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
    .clk_i, .rst_ni, .d_i(rgray_i), .q_o(rgray_s)
  );

  xclk_gray2bin #(.W(PW)) u_g2b (.gray_i(rgray_s), .bin_o(rbin_o));

  assign used     = wptr_o - rbin_o;
  assign free     = PW'(DEPTH) - used;
  assign full_no  = ready & (used != PW'(DEPTH));
  assign afull_no = ~(ready & (free <= ofs_i));
  assign push_o   = req_i & full_no;
  assign wptr_nx  = wptr_o + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o  <= '0;
      wgray_o <= '0;
    end else if (push_o) begin
      wptr_o  <= wptr_nx;
      wgray_o <= wptr_nx ^ (wptr_nx >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo_rd.sv
module xclk_fifo_rd #(
  parameter int DEPTH  = 64,
  parameter int STAGES = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [PW-1:0] wgray_i,
  input  logic [PW-1:0] ofs_i,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] rgray_o,
  output logic [PW-1:0] wbin_o,
  output logic          pop_o,
  output logic          empty_no,
  output logic          aempty_no
);
  timeunit 1ns; timeprecision 1ps;

  logic          ready;
  logic [PW-1:0] wgray_s, avail, rptr_nx;

  xclk_ptr_sync #(.W(1), .STAGES(STAGES)) u_rdy (
    .clk_i, .rst_ni, .d_i(1'b1), .q_o(ready)
  );

  xclk_ptr_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
    .clk_i, .rst_ni, .d_i(wgray_i), .q_o(wgray_s)
  );

  xclk_gray2bin #(.W(PW)) u_g2b (.gray_i(wgray_s), .bin_o(wbin_o));

  assign avail     = wbin_o - rptr_o;
  assign empty_no  = ready & (avail != '0);
  assign aempty_no = ready & (avail > ofs_i);
  assign pop_o     = req_i & empty_no;
  assign rptr_nx   = rptr_o + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_o  <= '0;
      rgray_o <= '0;
    end else if (pop_o) begin
      rptr_o  <= rptr_nx;
      rgray_o <= rptr_nx ^ (rptr_nx >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2,
  parameter int OFS_BASE    = 16,
  parameter int OFS_STEP    = 4
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic [1:0]       ofs_sel_i,
  input  logic             w_cs_ni,
  input  logic             w_en_i,
  input  logic             w_dir_i,
  input  logic [WIDTH-1:0] w_data_i,
  output logic             full_no,
  output logic             afull_no,
  input  logic             r_cs_ni,
  input  logic             r_en_i,
  input  logic             r_dir_i,
  output logic [WIDTH-1:0] r_data_o,
  output logic             empty_no,
  output logic             aempty_no
);
  timeunit 1ns; timeprecision 1ps;

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  ofs_sel_e        ofs_sel_q;
  logic [PW-1:0]   ofs_val;
  logic [PW-1:0]   wptr_bin, wgray, w_rbin;
  logic [PW-1:0]   rptr_bin, rgray, r_wbin;
  logic            push, pop, w_req, r_req;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] r_data_q;

  // preset latched by the release edge of reset
  always_ff @(posedge rst_ni) ofs_sel_q <= ofs_sel_e'(ofs_sel_i);

  assign ofs_val = PW'(ofs_value(ofs_sel_q, OFS_BASE, OFS_STEP));
  assign w_req   = ~w_cs_ni & w_en_i & w_dir_i;
  assign r_req   = ~r_cs_ni & r_en_i & ~r_dir_i;

  xclk_fifo_wr #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_wr (
    .clk_i   (wclk_i),
    .rst_ni  (rst_ni),
    .req_i   (w_req),
    .rgray_i (rgray),
    .ofs_i   (ofs_val),
    .wptr_o  (wptr_bin),
    .wgray_o (wgray),
    .rbin_o  (w_rbin),
    .push_o  (push),
    .full_no (full_no),
    .afull_no(afull_no)
  );

  xclk_fifo_rd #(.DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_rd (
    .clk_i    (rclk_i),
    .rst_ni   (rst_ni),
    .req_i    (r_req),
    .wgray_i  (wgray),
    .ofs_i    (ofs_val),
    .rptr_o   (rptr_bin),
    .rgray_o  (rgray),
    .wbin_o   (r_wbin),
    .pop_o    (pop),
    .empty_no (empty_no),
    .aempty_no(aempty_no)
  );

  always_ff @(posedge wclk_i) begin
    if (push) mem_q[wptr_bin[AW-1:0]] <= w_data_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)  r_data_q <= '0;
    else if (pop) r_data_q <= mem_q[rptr_bin[AW-1:0]];
  end

  assign r_data_o = r_data_q;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          full_no,
  input logic          afull_no,
  input logic          empty_no,
  input logic          aempty_no,
  input logic [PW-1:0] wptr_bin,
  input logic [PW-1:0] rptr_bin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] w_rbin,
  input logic [PW-1:0] r_wbin
);
  timeunit 1ns; timeprecision 1ps;

  logic [PW-1:0] w_used, r_avail;
  assign w_used  = wptr_bin - w_rbin;
  assign r_avail = r_wbin - rptr_bin;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    w_used <= PW'(DEPTH)) else $error("overflow"); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    r_avail <= PW'(DEPTH)) else $error("underflow"); // R6
  AST_FULL_HOLDS_WPTR: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr_bin)) else $error("write while full"); // R6
  AST_EMPTY_HOLDS_RPTR: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(rptr_bin)) else $error("read while empty"); // R6
  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1) else $error("write gray step"); // R1
  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray ^ $past(rgray)) <= 1) else $error("read gray step"); // R1
  AST_RST_WR_FLAGS: assert property (@(posedge wclk_i)
    !rst_ni |-> (!full_no && afull_no)) else $error("write flags in reset"); // R10
  AST_RST_RD_FLAGS: assert property (@(posedge rclk_i)
    !rst_ni |-> (!empty_no && !aempty_no)) else $error("read flags in reset"); // R10
  AST_AE_UNDER_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no) else $error("almost-empty above empty"); // R7
  AST_AF_AT_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_used == PW'(DEPTH)) |-> (!full_no && !afull_no)) else $error("full flags"); // R8
endmodule

bind xclk_fifo xclk_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .full_no  (full_no),
  .afull_no (afull_no),
  .empty_no (empty_no),
  .aempty_no(aempty_no),
  .wptr_bin (wptr_bin),
  .rptr_bin (rptr_bin),
  .wgray    (wgray),
  .rgray    (rgray),
  .w_rbin   (w_rbin),
  .r_wbin   (r_wbin)
);

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int W = 36;
  localparam int D = 64;

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] x;
  } vec_t;

  // offset select code and the threshold it must produce (R9)
  localparam vec_t VECS [4] = '{
    '{sel: 2'b00, x: 8'd16},
    '{sel: 2'b01, x: 8'd12},
    '{sel: 2'b10, x: 8'd8},
    '{sel: 2'b11, x: 8'd4}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_ni, w_cs_ni, w_en_i, w_dir_i, r_cs_ni, r_en_i, r_dir_i;
  logic [1:0]   ofs_sel_i;
  logic [W-1:0] w_data_i, r_data_o;
  logic         full_no, afull_no, empty_no, aempty_no;

  xclk_fifo u_dut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni, .ofs_sel_i,
    .w_cs_ni, .w_en_i, .w_dir_i, .w_data_i, .full_no, .afull_no,
    .r_cs_ni, .r_en_i, .r_dir_i, .r_data_o, .empty_no, .aempty_no
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int s, input int i);
    logic [31:0] v;
    v = (32'(i) * 32'h0101_0101) ^ 32'hC3A5_0F00;
    return {s[1:0], 2'b10, v};
  endfunction

  task automatic push(input logic [W-1:0] d);
    w_cs_ni = 1'b0; w_en_i = 1'b1; w_dir_i = 1'b1; w_data_i = d;
    @(negedge clk);
    w_cs_ni = 1'b1; w_en_i = 1'b0; w_dir_i = 1'b0;
  endtask

  task automatic pop();
    r_cs_ni = 1'b0; r_en_i = 1'b1; r_dir_i = 1'b0;
    @(negedge clk);
    r_cs_ni = 1'b1; r_en_i = 1'b0; r_dir_i = 1'b1;
  endtask

  task automatic wr_try(input logic cs_n, input logic en, input logic dir);
    w_cs_ni = cs_n; w_en_i = en; w_dir_i = dir; w_data_i = 36'hBAD_BAD_BAD;
    @(negedge clk);
    w_cs_ni = 1'b1; w_en_i = 1'b0; w_dir_i = 1'b0;
  endtask

  task automatic rd_try(input logic cs_n, input logic en, input logic dir);
    r_cs_ni = cs_n; r_en_i = en; r_dir_i = dir;
    @(negedge clk);
    r_cs_ni = 1'b1; r_en_i = 1'b0; r_dir_i = 1'b1;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_ni = 1'b0; ofs_sel_i = sel;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; ofs_sel_i = 2'b00; w_data_i = '0;
    w_cs_ni = 1'b1; w_en_i = 1'b0; w_dir_i = 1'b0;
    r_cs_ni = 1'b1; r_en_i = 1'b0; r_dir_i = 1'b1;

    // reset state and release timing
    repeat (2) @(negedge clk);
    chk("R10 full_no in reset", 64'(full_no), 64'd0);
    chk("R10 afull_no in reset", 64'(afull_no), 64'd1);
    chk("R10 empty_no in reset", 64'(empty_no), 64'd0);
    chk("R10 aempty_no in reset", 64'(aempty_no), 64'd0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R5 full_no after 1st edge", 64'(full_no), 64'd0);
    @(negedge clk);
    chk("R5 full_no after 2nd edge", 64'(full_no), 64'd1);
    chk("R10 r_data_o reset value", 64'(r_data_o), 64'd0);

    // one pass per offset preset
    for (int v = 0; v < 4; v++) begin
      int x;
      x = int'(VECS[v].x);
      do_reset(VECS[v].sel);
      for (int i = 0; i < x; i++) push(pat(v, i));
      repeat (2) @(negedge clk);
      chk($sformatf("R7 aempty_no at count=X sel%0d", v), 64'(aempty_no), 64'd0);
      chk($sformatf("R4 empty_no with data sel%0d", v), 64'(empty_no), 64'd1);
      push(pat(v, x));
      repeat (2) @(negedge clk);
      chk($sformatf("R7 aempty_no at count=X+1 sel%0d", v), 64'(aempty_no), 64'd1);
      for (int i = x + 1; i < D - x - 1; i++) push(pat(v, i));
      chk($sformatf("R8 afull_no at free=X+1 sel%0d", v), 64'(afull_no), 64'd1);
      push(pat(v, D - x - 1));
      chk($sformatf("R8 afull_no at free=X sel%0d", v), 64'(afull_no), 64'd0);
      for (int i = D - x; i < D - 1; i++) push(pat(v, i));
      chk($sformatf("R5 full_no at 63 words sel%0d", v), 64'(full_no), 64'd1);
      push(pat(v, D - 1));
      chk($sformatf("R1 full_no at 64 words sel%0d", v), 64'(full_no), 64'd0);
      push(36'hBAD_BAD_BAD); // R6: must be dropped
      for (int i = 0; i < D; i++) begin
        pop();
        chk($sformatf("R1 order sel%0d word%0d", v, i), 64'(r_data_o), 64'(pat(v, i)));
        if (i == 1) chk($sformatf("R5 full_no 1 edge after read sel%0d", v), 64'(full_no), 64'd0);
        if (i == 2) chk($sformatf("R5 full_no 2 edges after read sel%0d", v), 64'(full_no), 64'd1);
      end
      chk($sformatf("R4 empty_no after last read sel%0d", v), 64'(empty_no), 64'd0);
      pop();
      chk($sformatf("R6 read while empty sel%0d", v), 64'(r_data_o), 64'(pat(v, D - 1)));
    end

    // preset is frozen after release: X stays 4
    ofs_sel_i = 2'b00;
    for (int i = 0; i < 5; i++) push(pat(7, i));
    repeat (2) @(negedge clk);
    chk("R9 select change after release ignored", 64'(aempty_no), 64'd1);
    for (int i = 0; i < 5; i++) begin
      pop();
      chk("R1 order after select change", 64'(r_data_o), 64'(pat(7, i)));
    end

    // write qualifiers
    wr_try(1'b1, 1'b1, 1'b1);
    wr_try(1'b0, 1'b0, 1'b1);
    wr_try(1'b0, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 unqualified writes store nothing", 64'(empty_no), 64'd0);
    push(pat(9, 1));
    chk("R4 empty_no at write edge", 64'(empty_no), 64'd0);
    @(negedge clk);
    chk("R4 empty_no one edge later", 64'(empty_no), 64'd0);
    @(negedge clk);
    chk("R4 empty_no two edges later", 64'(empty_no), 64'd1);

    // read qualifiers
    rd_try(1'b1, 1'b1, 1'b0);
    rd_try(1'b0, 1'b0, 1'b0);
    rd_try(1'b0, 1'b1, 1'b1);
    chk("R3 unqualified reads keep data", 64'(r_data_o), 64'(pat(7, 4)));
    chk("R3 unqualified reads keep word", 64'(empty_no), 64'd1);
    pop();
    chk("R3 qualified read data", 64'(r_data_o), 64'(pat(9, 1)));
    chk("R4 empty_no after read", 64'(empty_no), 64'd0);

    // reset applied mid-run
    for (int i = 0; i < 3; i++) push(pat(11, i));
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R10 full_no on reset", 64'(full_no), 64'd0);
    chk("R10 afull_no on reset", 64'(afull_no), 64'd1);
    chk("R10 empty_no on reset", 64'(empty_no), 64'd0);
    chk("R10 aempty_no on reset", 64'(aempty_no), 64'd0);
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 no stale words after reset", 64'(empty_no), 64'd0);

    summary();
    $finish;
  end
endmodule